// File: doc/BRIEF.md
# Shared-Bus SPI Master with Per-Target Settings

This block drives one SPI bus (serial clock, master-out data, master-in data) that several slave devices share. Each slave has its own active-low select line. A small table holds the bus settings for each slave: clock polarity, clock phase, clock divider, word size and bit order. Software fills the table through a plain register-write port.

A requester asks for a transfer with a valid/ready handshake. The request names the target slave and the number of words. The controller latches that slave's settings only while it is idle with every select released. It then moves the serial clock to the new idle level and waits a guard time before it pulls the select low. It shifts the words back to back, feeding transmit words from a side input that it acknowledges with a pop strobe, and returns each received word on a valid strobe. After the final clock edge it waits the guard time again and releases the select. A clock-level change therefore never lands on a selected slave.

Top module: `spi_multi_master`

## Requirements
- R1: After reset every `cs_n` line is high. At most one line is ever low, and during a transfer it is line `req_dev`.
- R2: The table write port takes `cfg_wdata` with bit 0 = CPOL, bit 1 = CPHA, bits 4:2 = divider code k (SCK period 2^(k+1) system clocks), bit 5 = word size (0: 8 bits, 1: 16 bits) and bit 6 = order (0: MSB first, 1: LSB first). Every entry resets to all zeros.
- R3: `sck` idles at the CPOL of the most recently accepted request (0 after reset). It changes to a new idle level only while every select is high. `cs_n` falls exactly GUARD_CYC cycles after the acceptance edge, and `sck` does not change in between.
- R4: With CPHA=0, `mosi` holds each bit before the leading SCK edge, and both sides sample on leading edges. With CPHA=1, data changes on leading edges and is sampled on trailing edges.
- R5: Each SCK half-period lasts 2^k system clocks. The first edge of a word comes 2^k clocks after the word starts.
- R6: A transfer of n words of N bits produces exactly 2·N·n SCK edges.
- R7: Transmitted and received words follow the target's bit order. `rx_data` is right-aligned and zero-extended to 16 bits.
- R8: A request shifts `req_len`+1 words under one select. `tx_pop` pulses once for each word taken from `tx_data`, and `rx_valid` pulses once for each word received.
- R9: `cs_n` rises exactly GUARD_CYC+1 cycles after the final SCK edge, with the shifter already idle.
- R10: `req_ready` is high only while idle. A request raised during a transfer waits until the select has been released. `busy` is high from the acceptance edge until the select is released.
- R11: A table write made during a transfer does not change that transfer. The write takes effect from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Settings table write strobe |
| cfg_addr | input | 2 | Table entry to write |
| cfg_wdata | input | 7 | Settings word (R2 encoding) |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_dev | input | 2 | Target slave index |
| req_len | input | 8 | Number of words minus one |
| tx_data | input | 16 | Next transmit word, right-aligned |
| tx_pop | output | 1 | Pulse: current `tx_data` word was taken |
| rx_valid | output | 1 | Pulse: `rx_data` holds a received word |
| rx_data | output | 16 | Received word, right-aligned |
| busy | output | 1 | Transfer in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Master-out serial data |
| miso | input | 1 | Master-in serial data |
| cs_n | output | 4 | Active-low slave selects |

## Verification
The assertions assume that the block that drives the shifter never starts a word while one is still shifting. They also assume that `GUARD_CYC` is at least one, so the clock-level move and the select assertion fall on different edges. The bench keeps within these limits. It raises a new request only after every word of the previous one has been popped. It changes `tx_data` only after the pop strobe, long before the next word is loaded. Its slave model drives `miso` on the edge opposite the sampling edge, so every sampled bit is held for at least one full system clock.

// File: rtl/spimd_pkg.sv
package spimd_pkg;

    localparam int DATA_W = 16;
    localparam int DIV_W  = 3;

    // Field order matches the bit layout of the settings write word.
    typedef struct packed {
        logic             lsb_first;
        logic             wide;
        logic [DIV_W-1:0] div;
        logic             cpha;
        logic             cpol;
    } dev_cfg_t;

    localparam int CFG_W = $bits(dev_cfg_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_RUN,
        ST_TRAIL
    } seq_state_t;

    function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = v[DATA_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/spimd_cfg_table.sv
module spimd_cfg_table
    import spimd_pkg::*;
#(
    parameter int NDEV  = 4,
    parameter int DEV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [DEV_W-1:0] waddr,
    input  dev_cfg_t         wdata,
    input  logic [DEV_W-1:0] raddr,
    output dev_cfg_t         rdata
);

    dev_cfg_t tbl_d [NDEV];
    dev_cfg_t tbl_q [NDEV];

    always_comb begin
        for (int i = 0; i < NDEV; i++) begin
            tbl_d[i] = tbl_q[i];
        end
        if (we) begin
            tbl_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NDEV; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NDEV; i++) begin
                tbl_q[i] <= tbl_d[i];
            end
        end
    end

    assign rdata = tbl_q[raddr];

endmodule

// File: rtl/spimd_shifter.sv
module spimd_shifter
    import spimd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  dev_cfg_t          cfg,
    input  logic [DATA_W-1:0] word,
    input  logic              miso,
    output logic              ph,
    output logic              mosi,
    output logic              busy,
    output logic              taken,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data
);

    localparam int CNT_W  = (1 << DIV_W) - 1;
    localparam int EDGE_W = $clog2(2 * DATA_W);

    typedef struct packed {
        logic              busy;
        logic              ph;
        logic [CNT_W-1:0]  cnt;
        logic [EDGE_W-1:0] ecnt;
        logic [DATA_W-1:0] txsr;
        logic [DATA_W-1:0] rxsr;
        logic              mosi;
        logic              taken;
        logic              rxv;
        logic [DATA_W-1:0] rxd;
    } sh_t;

    sh_t q, d;

    logic [CNT_W-1:0]  half_m1;
    logic [EDGE_W-1:0] last_edge;
    logic [DATA_W-1:0] masked;
    logic [DATA_W-1:0] ordered;
    logic              lead;
    logic              samp;
    logic              shout;

    always_comb begin
        half_m1   = CNT_W'((32'd1 << cfg.div) - 32'd1);
        last_edge = cfg.wide ? EDGE_W'(2 * DATA_W - 1) : EDGE_W'(DATA_W - 1);
        masked    = cfg.wide ? word : {{(DATA_W/2){1'b0}}, word[DATA_W/2-1:0]};
        ordered   = cfg.lsb_first ? bit_rev(masked)
                  : (cfg.wide ? masked : (masked << (DATA_W/2)));
        lead      = ~q.ecnt[0];
        samp      = lead ^ cfg.cpha;
        shout     = cfg.cpha ? lead : (~lead && (q.ecnt != last_edge));

        d       = q;
        d.taken = 1'b0;
        d.rxv   = 1'b0;
        if (start) begin
            d.busy  = 1'b1;
            d.ph    = 1'b0;
            d.cnt   = '0;
            d.ecnt  = '0;
            d.rxsr  = '0;
            d.taken = 1'b1;
            if (!cfg.cpha) begin
                d.mosi = ordered[DATA_W-1];
                d.txsr = ordered << 1;
            end else begin
                d.txsr = ordered;
            end
        end else if (q.busy) begin
            if (q.cnt == half_m1) begin
                d.cnt = '0;
                d.ph  = ~q.ph;
                if (samp) begin
                    d.rxsr = {q.rxsr[DATA_W-2:0], miso};
                end
                if (shout) begin
                    d.mosi = q.txsr[DATA_W-1];
                    d.txsr = q.txsr << 1;
                end
                if (q.ecnt == last_edge) begin
                    d.busy = 1'b0;
                    d.rxv  = 1'b1;
                    d.rxd  = cfg.lsb_first
                           ? (bit_rev(d.rxsr) >> (cfg.wide ? 0 : DATA_W/2))
                           : d.rxsr;
                end else begin
                    d.ecnt = q.ecnt + 1'b1;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ph       = q.ph;
    assign mosi     = q.mosi;
    assign busy     = q.busy;
    assign taken    = q.taken;
    assign rx_valid = q.rxv;
    assign rx_data  = q.rxd;

    // R8: the sequencer never starts a word on top of a running one
    a_r8_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.busy);

    // R6: once the shifter goes idle the clock phase is back at idle
    a_r6_idle_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> (q.ph == 1'b0));

endmodule

// File: rtl/spi_multi_master.sv
module spi_multi_master
    import spimd_pkg::*;
#(
    parameter int NDEV      = 4,
    parameter int GUARD_CYC = 2,
    parameter int LEN_W     = 8,
    localparam int DEV_W    = $clog2(NDEV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DEV_W-1:0]  cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NDEV-1:0]   cs_n
);

    localparam int GCNT_W = $clog2(GUARD_CYC + 1);

    typedef struct packed {
        seq_state_t        st;
        dev_cfg_t          cfg;
        logic [DEV_W-1:0]  dev;
        logic [LEN_W-1:0]  left;
        logic [GCNT_W-1:0] gcnt;
        logic              sel;
    } seq_t;

    seq_t     q, d;
    dev_cfg_t tbl_rdata;
    logic     sh_start;
    logic     sh_ph;
    logic     sh_busy;
    logic     sh_rxv;

    spimd_cfg_table #(
        .NDEV  (NDEV),
        .DEV_W (DEV_W)
    ) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (dev_cfg_t'(cfg_wdata)),
        .raddr (req_dev),
        .rdata (tbl_rdata)
    );

    spimd_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (sh_start),
        .cfg      (q.cfg),
        .word     (tx_data),
        .miso     (miso),
        .ph       (sh_ph),
        .mosi     (mosi),
        .busy     (sh_busy),
        .taken    (tx_pop),
        .rx_valid (sh_rxv),
        .rx_data  (rx_data)
    );

    always_comb begin
        d        = q;
        sh_start = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st   = ST_SETTLE;
                    d.cfg  = tbl_rdata;
                    d.dev  = req_dev;
                    d.left = req_len;
                    d.gcnt = '0;
                end
            end
            ST_SETTLE: begin
                if (q.gcnt == GCNT_W'(GUARD_CYC - 1)) begin
                    d.st     = ST_RUN;
                    d.sel    = 1'b1;
                    sh_start = 1'b1;
                end else begin
                    d.gcnt = q.gcnt + 1'b1;
                end
            end
            ST_RUN: begin
                if (sh_rxv) begin
                    if (q.left == '0) begin
                        d.st   = ST_TRAIL;
                        d.gcnt = '0;
                    end else begin
                        d.left   = q.left - 1'b1;
                        sh_start = 1'b1;
                    end
                end
            end
            ST_TRAIL: begin
                if (q.gcnt == GCNT_W'(GUARD_CYC - 1)) begin
                    d.st  = ST_IDLE;
                    d.sel = 1'b0;
                end else begin
                    d.gcnt = q.gcnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    for (genvar i = 0; i < NDEV; i++) begin : g_sel
        assign cs_n[i] = ~(q.sel && (q.dev == DEV_W'(i)));
    end

    assign sck       = q.cfg.cpol ^ sh_ph;
    assign req_ready = (q.st == ST_IDLE);
    assign busy      = (q.st != ST_IDLE);
    assign rx_valid  = sh_rxv;

    a_r1_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cs_n) |-> $stable(q.cfg));

    a_r3_quiet_select: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(&cs_n) |-> $stable(sck));

    a_r9_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&cs_n) |-> (!sh_busy && !$past(sh_busy)));

    a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && !req_ready));

endmodule

// File: tb/sim_spi_multi_master.sv
module sim_spi_multi_master;

    localparam int G    = 2;
    localparam int NDEV = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [6:0]  cfg_wdata;
    logic        req_valid;
    logic        req_ready;
    logic [1:0]  req_dev;
    logic [7:0]  req_len;
    logic [15:0] tx_data;
    logic        tx_pop;
    logic        rx_valid;
    logic [15:0] rx_data;
    logic        busy;
    logic        sck;
    logic        mosi;
    logic        miso;
    logic [3:0]  cs_n;

    always #4 clk = ~clk;

    spi_multi_master #(.NDEV(NDEV), .GUARD_CYC(G), .LEN_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_dev(req_dev), .req_len(req_len), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy), .sck(sck),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // bench mirror of the settings table and transfer slots
    logic [6:0]  mir [NDEV];
    logic [6:0]  p_cfg, a_cfg;
    logic [1:0]  p_dev, a_dev;
    int          p_n, a_n, p_acc, a_acc;
    logic [15:0] p_tx [4];
    logic [15:0] p_sl [4];
    logic [15:0] a_tx [4];
    logic [15:0] a_sl [4];
    logic [15:0] txq [4];
    int          tx_idx = 0;
    int          tx_n = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int nbits(input logic [6:0] c);
        return c[5] ? 16 : 8;
    endfunction

    function automatic int halfp(input logic [6:0] c);
        return 1 << c[4:2];
    endfunction

    function automatic logic [15:0] wmask(input logic [15:0] w, input logic [6:0] c);
        return c[5] ? w : {8'h00, w[7:0]};
    endfunction

    function automatic logic sl_bit(input int g);
        int n = nbits(a_cfg);
        int w = g / n;
        int i = g % n;
        if (w >= a_n) return 1'b0;
        return a_cfg[6] ? a_sl[w][i] : a_sl[w][n-1-i];
    endfunction

    // slave model and protocol monitor
    logic        prev_sck = 1'b0;
    logic        prev_csall = 1'b1;
    bit          active = 0;
    int          edges, wi, bitsin, rxi, lc, tc, fe_ref, last_edge_c, sck_chg_c;
    logic [15:0] cur;

    always @(negedge clk) begin
        logic csall;
        logic lead;
        logic samp;
        cyc++;
        csall = &cs_n;
        if (rst_n && sck !== prev_sck) sck_chg_c = cyc;
        if (rst_n && prev_csall && !csall) begin
            a_cfg = p_cfg; a_dev = p_dev; a_n = p_n; a_acc = p_acc;
            for (int i = 0; i < 4; i++) begin a_tx[i] = p_tx[i]; a_sl[i] = p_sl[i]; end
            active = 1; edges = 0; wi = 0; bitsin = 0; rxi = 0; lc = 0; tc = 0; cur = '0;
            fe_ref = cyc;
            chk(cs_n == ~(4'b1 << a_dev), "R1", "select line", cs_n, ~(4'b1 << a_dev));
            chk(cyc - a_acc == G, "R3", "accept to select", cyc - a_acc, G);
            chk(sck == a_cfg[0], "R3", "idle level at select", sck, a_cfg[0]);
            chk(sck_chg_c <= a_acc, "R3", "sck moved after accept", sck_chg_c, a_acc);
            if (!a_cfg[1]) miso = sl_bit(0);
        end else if (rst_n && active && !csall && sck !== prev_sck) begin
            edges++;
            lead = (sck != a_cfg[0]);
            samp = lead ^ a_cfg[1];
            if (edges == 1)
                chk(cyc - fe_ref == halfp(a_cfg), "R2 R5", "first edge delay",
                    cyc - fe_ref, halfp(a_cfg));
            if (samp) begin
                if (a_cfg[6]) cur[bitsin] = mosi;
                else cur = {cur[14:0], mosi};
                bitsin++;
                if (bitsin == nbits(a_cfg)) begin
                    if (wi < a_n)
                        chk(cur == wmask(a_tx[wi], a_cfg), "R4 R7", "mosi word",
                            cur, wmask(a_tx[wi], a_cfg));
                    wi++; bitsin = 0; cur = '0;
                end
            end
            if (!a_cfg[1] && !lead) begin
                tc++;
                miso = sl_bit(tc);
            end
            if (a_cfg[1] && lead) begin
                miso = sl_bit(lc);
                lc++;
            end
            last_edge_c = cyc;
        end
        if (rst_n && active && !prev_csall && csall) begin
            chk(cyc - last_edge_c == G + 1, "R9", "last edge to release",
                cyc - last_edge_c, G + 1);
            chk(edges == 2 * nbits(a_cfg) * a_n, "R6", "edge count",
                edges, 2 * nbits(a_cfg) * a_n);
            chk(rxi == a_n, "R8", "received words", rxi, a_n);
            chk(wi == a_n, "R8", "sent words", wi, a_n);
            chk(busy == 1'b0, "R10", "busy at release", busy, 0);
            active = 0;
        end
        if (rst_n && rx_valid) begin
            if (rxi < a_n)
                chk(rx_data == wmask(a_sl[rxi], a_cfg), "R7", "rx word",
                    rx_data, wmask(a_sl[rxi], a_cfg));
            rxi++;
        end
        if (rst_n && tx_pop) begin
            tx_idx++;
            if (tx_idx < tx_n) tx_data = txq[tx_idx];
        end
        prev_sck = sck;
        prev_csall = csall;
    end

    task automatic write_cfg(input logic [1:0] dev, input logic [6:0] v);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_addr = dev; cfg_wdata = v;
        @(negedge clk); #1;
        cfg_we = 1'b0;
        mir[dev] = v;
    endtask

    task automatic run_txn(input logic [1:0] dev, input int n,
                           input logic [15:0] w0, input logic [15:0] w1,
                           input logic [15:0] w2, input logic [15:0] w3,
                           input logic [15:0] s0, input logic [15:0] s1,
                           input logic [15:0] s2, input logic [15:0] s3);
        while (tx_idx < tx_n) begin @(negedge clk); #1; end
        p_dev = dev; p_n = n; p_cfg = mir[dev];
        p_tx[0] = w0; p_tx[1] = w1; p_tx[2] = w2; p_tx[3] = w3;
        p_sl[0] = s0; p_sl[1] = s1; p_sl[2] = s2; p_sl[3] = s3;
        for (int i = 0; i < 4; i++) txq[i] = p_tx[i];
        tx_idx = 0; tx_n = n; tx_data = txq[0];
        req_dev = dev; req_len = 8'(n - 1); req_valid = 1'b1;
        if (busy) chk(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
        while (!req_ready) begin @(negedge clk); #1; end
        chk(busy == 1'b0, "R10", "accepted only when idle", busy, 0);
        p_acc = cyc + 1;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (busy || tx_idx < tx_n || active) begin @(negedge clk); #1; end
        repeat (3) @(negedge clk);
        #1;
    endtask

    initial begin
        int wd = 0;
        while (wd < 150000) begin @(posedge clk); wd++; end
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", wd);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] r [8];
        process::self().srandom(32'd1234);
        rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; req_valid = 0;
        req_dev = 0; req_len = 0; tx_data = 0; miso = 0;
        sck_chg_c = 0; last_edge_c = 0;
        for (int i = 0; i < NDEV; i++) mir[i] = '0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk(cs_n == 4'hF, "R1", "reset selects", cs_n, 4'hF);
        chk(req_ready == 1'b1, "R10", "reset ready", req_ready, 1);
        chk(busy == 1'b0, "R10", "reset busy", busy, 0);
        chk(sck == 1'b0, "R3", "reset sck level", sck, 0);
        chk(rx_valid == 1'b0, "R8", "reset rx_valid", rx_valid, 0);

        // R2 reset defaults: mode 0, divide by 2, 8 bits, MSB first
        run_txn(2'd0, 1, 16'h00A5, 0, 0, 0, 16'h003C, 0, 0, 0);
        drain();

        // one device per mode, different width, order and divider
        write_cfg(2'd1, {1'b0, 1'b1, 3'd1, 1'b1, 1'b1});   // mode 3, 16 bit
        write_cfg(2'd2, {1'b1, 1'b0, 3'd2, 1'b1, 1'b0});   // mode 1, 8 bit LSB
        write_cfg(2'd3, {1'b1, 1'b1, 3'd0, 1'b0, 1'b1});   // mode 2, 16 bit LSB
        run_txn(2'd1, 2, 16'hBEEF, 16'h1234, 0, 0, 16'hC0DE, 16'h8001, 0, 0);
        run_txn(2'd0, 1, 16'h005A, 0, 0, 0, 16'h00F0, 0, 0, 0);   // CPOL 1 -> 0
        run_txn(2'd2, 3, 16'h0081, 16'h0003, 16'h00C0, 0, 16'h0001, 16'h0080, 16'h00AA, 0);
        run_txn(2'd3, 2, 16'h8000, 16'h0001, 0, 0, 16'hF00F, 16'h7FFE, 0, 0);
        drain();

        // slowest divider
        write_cfg(2'd0, {1'b0, 1'b0, 3'd7, 1'b0, 1'b0});
        run_txn(2'd0, 1, 16'h0096, 0, 0, 0, 16'h0069, 0, 0, 0);
        drain();

        // R11: rewrite the active entry mid-transfer
        run_txn(2'd2, 2, 16'h0011, 16'h0022, 0, 0, 16'h0033, 16'h0044, 0, 0);
        write_cfg(2'd2, {1'b0, 1'b1, 3'd0, 1'b0, 1'b1});
        run_txn(2'd2, 1, 16'hA1B2, 0, 0, 0, 16'h5A5A, 0, 0, 0);
        drain();
        write_cfg(2'd0, 7'd0);

        // constrained random
        for (int t = 0; t < 40; t++) begin
            logic [1:0] dv;
            logic [6:0] c;
            int n;
            dv = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 2) == 0) begin
                c = 7'($urandom);
                c[4:2] = 3'($urandom_range(0, 3));
                write_cfg(dv, c);
            end
            n = $urandom_range(1, 4);
            for (int i = 0; i < 8; i++) r[i] = 16'($urandom);
            run_txn(dv, n, r[0], r[1], r[2], r[3], r[4], r[5], r[6], r[7]);
        end
        drain();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule